// File: doc/BRIEF.md
# Floppy Drive Control Sequencer

This block owns the control lines of one floppy drive: drive select, motor enable and a density line that the host may set. A host issues one command at a time over a valid/ready handshake: select the drive, deselect it, switch the motor, set a numbered user pin, clear the user pins, or return the bus to idle. Every command ends with a single-cycle done pulse carrying an acknowledge code. Commands that need the drive to settle hold off that pulse for a delay taken from an input port, counted in clock cycles.

All three drive lines model open-drain outputs. A line that is asserted is pulled to 0, and a line that is negated is released to 1. The block remembers whether the motor is running, so a motor request for the state it is already in returns at once and leaves the line alone. The spin-up wait applies only when the motor is switched on. While a wait is counting, the handshake refuses new commands.

Top module: `fdc_ctrl_seq`

## Requirements
- R1: The outputs `sel_n`, `mot_n` and `dens_n` are active low. An asserted line reads 0 and a negated line reads 1.
- R2: Opcode 0 (select) asserts `sel_n` and raises `unit_sel` on the accepting clock edge. `done` with ack 0 is then high in the cycle after the edge that falls `sel_delay`+1 edges after the accepting edge.
- R3: Opcode 1 (deselect) negates `sel_n` and clears `unit_sel`. It completes immediately.
- R4: Opcode 2 (motor) with `cmd_arg` equal to the current motor state (1 = running) leaves `mot_n` unchanged and completes immediately with ack 0.
- R5: Opcode 2 with `cmd_arg`=1 while the motor is stopped asserts `mot_n` on the accepting edge and delays `done` by `spin_delay`+1 edges, counted as in R2. With `cmd_arg`=0 while the motor is running, it negates `mot_n` and completes immediately.
- R6: Opcode 3 (bus reset) negates `sel_n` and `mot_n`, clears `unit_sel` and records the motor as stopped. It completes immediately.
- R7: Opcode 4 (set user pin) with `cmd_pin`=2 drives the density line to the level in `cmd_arg` (1 = asserted) and acks 0. Any other pin number acks 1 (bad pin) and leaves `dens_n` unchanged.
- R8: Opcode 5 (clear user pins) negates `dens_n`. It completes immediately with ack 0.
- R9: `cmd_ready` is low while a delay counts. A command presented during that time is not taken.
- R10: An immediate command raises `done` in the cycle right after its accepting edge. `done` lasts one cycle unless another command is accepted at once.
- R11: Opcodes 6 and 7 ack 2 (bad command) immediately and change no output line.
- R12: After reset all lines are negated, `unit_sel` is 0, the motor reads as stopped, `done` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_arg | input | 1 | Motor on/off or user pin level |
| cmd_pin | input | PIN_W | User pin number |
| sel_delay | input | DLY_W | Select settle time in cycles |
| spin_delay | input | DLY_W | Motor spin-up time in cycles |
| done | output | 1 | One-cycle completion pulse |
| ack_code | output | 2 | 0 OK, 1 bad pin, 2 bad command |
| sel_n | output | 1 | Drive select, active low |
| mot_n | output | 1 | Motor enable, active low |
| dens_n | output | 1 | Density line, active low |
| unit_sel | output | 1 | A unit is currently selected |

## Verification
The select and motor-on commands are swept over delays from 0 to 6 cycles. The measured latency separates a correct count from an off-by-one or a skipped wait, and the line level at the first cycle shows that each line is driven before the acknowledge. Each motor request is repeated in both states, which separates the true no-op from a re-triggered spin-up. The user-pin command is swept over every pin number at both levels, so that only pin 2 moves the density line. A command presented during a wait, plus bus reset followed by motor on, shows that refused commands are dropped and that the motor record is cleared.

// File: rtl/fcs_pkg.sv
// Package: shared opcodes, acknowledge codes, FSM state and the
// line-update request bundle for the floppy control sequencer.
package fcs_pkg;

    typedef logic [2:0] fcs_op_t;

    localparam fcs_op_t OP_SELECT    = 3'd0;
    localparam fcs_op_t OP_DESELECT  = 3'd1;
    localparam fcs_op_t OP_MOTOR     = 3'd2;
    localparam fcs_op_t OP_BUS_RESET = 3'd3;
    localparam fcs_op_t OP_SET_PIN   = 3'd4;
    localparam fcs_op_t OP_CLR_PINS  = 3'd5;

    localparam logic [1:0] ACK_OK      = 2'd0;
    localparam logic [1:0] ACK_BAD_PIN = 2'd1;
    localparam logic [1:0] ACK_BAD_CMD = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fcs_state_e;

    // One-cycle update strobes from the sequencer to the line registers
    typedef struct packed {
        logic sel_set;
        logic sel_clr;
        logic mot_set;
        logic mot_clr;
        logic dens_we;
        logic dens_lvl;
    } fcs_line_req_t;

endpackage

// File: rtl/fcs_delay_timer.sv
// Module: fcs_delay_timer
// Down-counter that implements the settling waits. A load writes the
// wait length, and the count then drops by one per cycle down to zero.
// Assumes: load is only pulsed when a new wait starts; `expired` is
// high whenever the count is zero.
module fcs_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load a new wait length or count the current one down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val)); // R2
    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1)); // R5

endmodule

// File: rtl/fcs_cmd_fsm.sv
// Module: fcs_cmd_fsm
// Takes commands over valid/ready, decodes them into line-update strobes,
// starts the delay timer for select and motor spin-up, and issues a
// one-cycle done pulse with an acknowledge code.
// Assumes: motor_on reflects the line registers after the previous edge;
// tmr_expired comes from a timer loaded through tmr_load.
module fcs_cmd_fsm
    import fcs_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int PIN_W    = 4,
    parameter int DENS_PIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  fcs_op_t           cmd_op,
    input  logic              cmd_arg,
    input  logic [PIN_W-1:0]  cmd_pin,
    input  logic [DLY_W-1:0]  sel_delay,
    input  logic [DLY_W-1:0]  spin_delay,
    input  logic              motor_on,
    input  logic              tmr_expired,
    output fcs_line_req_t     line_req,
    output logic              tmr_load,
    output logic [DLY_W-1:0]  tmr_val,
    output logic              done,
    output logic [1:0]        ack_code
);

    localparam logic [PIN_W-1:0] DENS_PIN_V = PIN_W'(DENS_PIN);

    fcs_state_e    state_q;
    logic          accept;
    fcs_line_req_t dec_req;
    logic          dec_wait;
    logic [1:0]    dec_ack;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    // Decode the presented command into strobes, wait request and ack
    always_comb begin
        dec_req  = '0;
        dec_wait = 1'b0;
        dec_ack  = ACK_OK;
        tmr_val  = sel_delay;
        case (cmd_op)
            OP_SELECT: begin
                dec_req.sel_set = 1'b1;
                dec_wait        = 1'b1;
                tmr_val         = sel_delay;
            end
            OP_DESELECT: begin
                dec_req.sel_clr = 1'b1;
            end
            OP_MOTOR: begin
                if (cmd_arg != motor_on) begin
                    if (cmd_arg) begin
                        dec_req.mot_set = 1'b1;
                        dec_wait        = 1'b1;
                        tmr_val         = spin_delay;
                    end else begin
                        dec_req.mot_clr = 1'b1;
                    end
                end
            end
            OP_BUS_RESET: begin
                dec_req.sel_clr = 1'b1;
                dec_req.mot_clr = 1'b1;
            end
            OP_SET_PIN: begin
                if (cmd_pin == DENS_PIN_V) begin
                    dec_req.dens_we  = 1'b1;
                    dec_req.dens_lvl = cmd_arg;
                end else begin
                    dec_ack = ACK_BAD_PIN;
                end
            end
            OP_CLR_PINS: begin
                dec_req.dens_we  = 1'b1;
                dec_req.dens_lvl = 1'b0;
            end
            default: begin
                dec_ack = ACK_BAD_CMD;
            end
        endcase
    end

    assign line_req = accept ? dec_req : '0;
    assign tmr_load = accept && dec_wait;

    // Sequence state, completion pulse and registered acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            done     <= 1'b0;
            ack_code <= ACK_OK;
        end else begin
            done <= 1'b0;
            if (accept) begin
                ack_code <= dec_ack;
                if (dec_wait) begin
                    state_q <= ST_WAIT;
                end else begin
                    done <= 1'b1;
                end
            end else if (state_q == ST_WAIT && tmr_expired) begin
                done    <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !tmr_expired) |=> !done); // R9
    AST_IMMEDIATE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_wait) |=> done && cmd_ready); // R10

endmodule

// File: rtl/fcs_line_bank.sv
// Module: fcs_line_bank
// Holds the select, motor, density and unit-selected state and turns it
// into open-drain style pad levels (asserted = 0 when ACTIVE_LOW).
// Assumes: set and clear strobes for one line never arrive together.
module fcs_line_bank
    import fcs_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1,
    parameter int N_LINES    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fcs_line_req_t req,
    output logic          sel_pad,
    output logic          mot_pad,
    output logic          dens_pad,
    output logic          unit_sel,
    output logic          motor_on
);

    logic               sel_q;
    logic               mot_q;
    logic               dens_q;
    logic               unit_q;
    logic [N_LINES-1:0] line_on;
    logic [N_LINES-1:0] pad_lvl;

    // Select line and the unit record move together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            unit_q <= 1'b0;
        end else if (req.sel_set) begin
            sel_q  <= 1'b1;
            unit_q <= 1'b1;
        end else if (req.sel_clr) begin
            sel_q  <= 1'b0;
            unit_q <= 1'b0;
        end
    end

    // Motor line doubles as the motor state record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mot_q <= 1'b0;
        end else if (req.mot_set) begin
            mot_q <= 1'b1;
        end else if (req.mot_clr) begin
            mot_q <= 1'b0;
        end
    end

    // Density line follows the user pin writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dens_q <= 1'b0;
        end else if (req.dens_we) begin
            dens_q <= req.dens_lvl;
        end
    end

    assign line_on = {dens_q, mot_q, sel_q};

    // Map each logical line to its pad level
    for (genvar i = 0; i < N_LINES; i++) begin : g_pad
        if (ACTIVE_LOW) begin : g_low
            assign pad_lvl[i] = ~line_on[i];
        end else begin : g_high
            assign pad_lvl[i] = line_on[i];
        end
    end

    assign sel_pad  = pad_lvl[0];
    assign mot_pad  = pad_lvl[1];
    assign dens_pad = pad_lvl[2];
    assign unit_sel = unit_q;
    assign motor_on = mot_q;

    AST_DESEL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (req.sel_clr && !req.sel_set) |=> (sel_pad == ACTIVE_LOW) && !unit_sel); // R3
    AST_PINS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (req.dens_we && !req.dens_lvl) |=> dens_pad == ACTIVE_LOW); // R8

endmodule

// File: rtl/fdc_ctrl_seq.sv
// Module: fdc_ctrl_seq (top)
// Floppy drive control sequencer. It joins the command FSM, the delay
// timer and the line bank. Outputs are active low, open-drain style.
// Assumes: sel_delay and spin_delay are stable while a wait counts.
module fdc_ctrl_seq
    import fcs_pkg::*;
#(
    parameter int DLY_W    = 16,
    parameter int PIN_W    = 4,
    parameter int DENS_PIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_arg,
    input  logic [PIN_W-1:0] cmd_pin,
    input  logic [DLY_W-1:0] sel_delay,
    input  logic [DLY_W-1:0] spin_delay,
    output logic             done,
    output logic [1:0]       ack_code,
    output logic             sel_n,
    output logic             mot_n,
    output logic             dens_n,
    output logic             unit_sel
);

    fcs_line_req_t    line_req;
    logic             motor_on;
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;

    fcs_cmd_fsm #(
        .DLY_W    (DLY_W),
        .PIN_W    (PIN_W),
        .DENS_PIN (DENS_PIN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_arg     (cmd_arg),
        .cmd_pin     (cmd_pin),
        .sel_delay   (sel_delay),
        .spin_delay  (spin_delay),
        .motor_on    (motor_on),
        .tmr_expired (tmr_expired),
        .line_req    (line_req),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .done        (done),
        .ack_code    (ack_code)
    );

    fcs_delay_timer #(
        .W (DLY_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fcs_line_bank #(
        .ACTIVE_LOW (1'b1),
        .N_LINES    (3)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (line_req),
        .sel_pad  (sel_n),
        .mot_pad  (mot_n),
        .dens_pad (dens_n),
        .unit_sel (unit_sel),
        .motor_on (motor_on)
    );

    assign accept = cmd_valid && cmd_ready;

    AST_SELECT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_SELECT) |=> !sel_n && unit_sel && !cmd_ready); // R2
    AST_MOTOR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_MOTOR && cmd_arg == !mot_n)
        |=> $stable(mot_n) && done && ack_code == ACK_OK); // R4
    AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_BUS_RESET) |=> sel_n && mot_n && !unit_sel); // R6
    AST_BAD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_SET_PIN && cmd_pin != PIN_W'(DENS_PIN))
        |=> done && ack_code == ACK_BAD_PIN && $stable(dens_n)); // R7
    AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op > OP_CLR_PINS)
        |=> done && ack_code == ACK_BAD_CMD && $stable({sel_n, mot_n, dens_n})); // R11

endmodule

// File: tb/fdc_ctrl_seq_tb.sv
module fdc_ctrl_seq_tb;

    localparam int DLY_W = 8;
    localparam int PIN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = '0;
    logic             cmd_arg = 1'b0;
    logic [PIN_W-1:0] cmd_pin = '0;
    logic [DLY_W-1:0] sel_delay = '0;
    logic [DLY_W-1:0] spin_delay = '0;
    logic             done;
    logic [1:0]       ack_code;
    logic             sel_n, mot_n, dens_n, unit_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    fdc_ctrl_seq #(.DLY_W(DLY_W), .PIN_W(PIN_W), .DENS_PIN(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_pin(cmd_pin),
        .sel_delay(sel_delay), .spin_delay(spin_delay), .done(done),
        .ack_code(ack_code), .sel_n(sel_n), .mot_n(mot_n), .dens_n(dens_n),
        .unit_sel(unit_sel)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one command. lat counts negedges from acceptance until done is
    // seen (1 = cycle right after the accepting edge).
    task automatic run_cmd(input logic [2:0] op, input logic arg, input int pin,
                           output int lat, output int ack, output int rdy1,
                           output int sel1, output int mot1, output int done_after);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_pin = PIN_W'(pin);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1; rdy1 = int'(cmd_ready); sel1 = int'(sel_n); mot1 = int'(mot_n);
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        ack = int'(ack_code);
        @(negedge clk);
        done_after = int'(done);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, ack, rdy1, sel1, mot1, dafter, exp_dens;
        logic [2:0] snap;
        repeat (3) @(negedge clk);
        // R12 / R1: reset state, all lines released high
        chk("R12 sel_n", int'(sel_n), 1);
        chk("R12 mot_n", int'(mot_n), 1);
        chk("R1 dens_n", int'(dens_n), 1);
        chk("R12 unit_sel", int'(unit_sel), 0);
        chk("R12 done", int'(done), 0);
        chk("R12 ready", int'(cmd_ready), 1);
        rst_n = 1'b1;

        // R2 / R3 / R9: select delay sweep then deselect
        for (int d = 0; d <= 6; d++) begin
            sel_delay = DLY_W'(d);
            run_cmd(3'd0, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R2 select latency", lat, d + 2);
            chk("R2 select ack", ack, 0);
            chk("R2 line asserted before ack", sel1, 0);
            chk("R2 unit_sel", int'(unit_sel), 1);
            chk("R9 ready low while waiting", rdy1, 0);
            chk("R10 done single cycle", dafter, 0);
            run_cmd(3'd1, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R3 deselect latency", lat, 1);
            chk("R3 sel_n released", int'(sel_n), 1);
            chk("R3 unit cleared", int'(unit_sel), 0);
            chk("R10 done single cycle", dafter, 0);
        end

        // R4 / R5: motor spin-up sweep and same-state requests
        for (int d = 0; d <= 6; d++) begin
            spin_delay = DLY_W'(d);
            run_cmd(3'd2, 1'b1, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R5 spin-up latency", lat, d + 2);
            chk("R5 mot_n asserted early", mot1, 0);
            chk("R5 mot_n on", int'(mot_n), 0);
            chk("R9 ready low during spin-up", rdy1, 0);
            run_cmd(3'd2, 1'b1, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R4 on-again latency", lat, 1);
            chk("R4 on-again ack", ack, 0);
            chk("R4 mot_n held", int'(mot_n), 0);
            run_cmd(3'd2, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R5 off latency", lat, 1);
            chk("R5 mot_n off", int'(mot_n), 1);
            run_cmd(3'd2, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R4 off-again latency", lat, 1);
            chk("R4 off-again ack", ack, 0);
            chk("R4 mot_n stays off", int'(mot_n), 1);
        end

        // R6: bus reset negates lines and clears the motor record
        sel_delay = 8'd2; spin_delay = 8'd3;
        run_cmd(3'd0, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
        run_cmd(3'd2, 1'b1, 0, lat, ack, rdy1, sel1, mot1, dafter);
        run_cmd(3'd3, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
        chk("R6 bus reset latency", lat, 1);
        chk("R6 sel_n", int'(sel_n), 1);
        chk("R6 mot_n", int'(mot_n), 1);
        chk("R6 unit_sel", int'(unit_sel), 0);
        run_cmd(3'd2, 1'b1, 0, lat, ack, rdy1, sel1, mot1, dafter);
        chk("R6 motor record cleared (spin-up again)", lat, 5);

        // R7: every pin number at both levels
        exp_dens = 0;
        for (int p = 0; p < 16; p++) begin
            for (int l = 0; l < 2; l++) begin
                run_cmd(3'd4, l[0], p, lat, ack, rdy1, sel1, mot1, dafter);
                if (p == 2) exp_dens = l;
                chk("R7 set pin ack", ack, (p == 2) ? 0 : 1);
                chk("R7 dens_n level", int'(dens_n), 1 - exp_dens);
                chk("R7 latency", lat, 1);
            end
        end

        // R8: clear user pins
        run_cmd(3'd4, 1'b1, 2, lat, ack, rdy1, sel1, mot1, dafter);
        chk("R8 dens asserted first", int'(dens_n), 0);
        run_cmd(3'd5, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
        chk("R8 dens_n released", int'(dens_n), 1);
        chk("R8 ack", ack, 0);

        // R11: unknown opcodes with lines in a mixed state
        run_cmd(3'd0, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
        for (int o = 6; o < 8; o++) begin
            snap = {sel_n, mot_n, dens_n};
            run_cmd(3'(o), 1'b1, 2, lat, ack, rdy1, sel1, mot1, dafter);
            chk("R11 bad command ack", ack, 2);
            chk("R11 latency", lat, 1);
            chk("R11 lines unchanged", int'({sel_n, mot_n, dens_n}), int'(snap));
        end

        // R9: a command presented during a wait is dropped
        run_cmd(3'd1, 1'b0, 0, lat, ack, rdy1, sel1, mot1, dafter);
        sel_delay = 8'd4;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 3'd1;
        chk("R9 ready low", int'(cmd_ready), 0);
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        repeat (3) @(negedge clk);
        chk("R9 refused deselect not taken", int'(sel_n), 0);
        chk("R9 unit still selected", int'(unit_sel), 1);
        chk("R9 no second done", int'(done), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule